// File: doc/BRIEF.md
# Future-Occupancy Slot Finder for One Execution Unit

This block books execution cycles for a single functional unit and the result bus that unit writes through. It holds two occupancy vectors, one per resource. Bit i of a vector covers the cycle i clocks after the current one. A 1 in that bit means the resource is already booked for that cycle, and a 0 means it is still open. An issue stage presents a request with two values: the number of cycles until the instruction's last source operand is ready, and the number of cycles the unit needs for the operation. In the same cycle, the block answers with the delay until execution starts and the delay until the result is written back. It can also answer that no slot was found, in which case the request stalls.

The search covers a short window of candidate start delays, beginning at the operand-ready delay. A candidate qualifies only when two conditions hold: the unit is open at that candidate, and the bus is open at the candidate plus the duration. The lowest qualifying candidate wins. On a grant, the block books the unit bit at the chosen start and the bus bit at the write-back delay. Every clock, both vectors move one position toward index 0, and an open cycle enters at the far end.

A request is always judged against vectors that already include every earlier booking and have already been shifted. Because of this, requests on consecutive cycles cannot claim the same unit or bus cycle.

Top module: `brt_slot_finder`

## Requirements
- R1: After synchronous active-low reset, both vectors are fully open, so a first request with ready delay S and duration D is granted with execute delay S and write-back delay S+D, provided S+D is below the table length.
- R2: A granted execute delay is never below the ready delay and exceeds it by at most WIN-1 cycles.
- R3: A granted write-back delay equals the granted execute delay plus the requested duration.
- R4: The granted execute delay is the smallest candidate in the window for which the unit bit is open and the bus bit at candidate plus duration is open; a bus conflict alone disqualifies a candidate.
- R5: When no candidate in the window qualifies, stall is raised, grant stays low, and no booking is made.
- R6: A candidate whose execute or write-back delay would reach or pass the table length counts as occupied, so requests near the end of the table stall rather than wrap.
- R7: On a grant, the unit bit at the execute delay and the bus bit at the write-back delay are booked at the next clock edge, together with the shift.
- R8: Both vectors shift by one position toward index 0 every clock, with a 0 entering at the top, so a booking made at delay E is seen at delay E-n after n clocks and is gone after E+1 clocks.
- R9: With no request, grant and stall are both low and only the shift changes the vectors.
- R10: Requests on consecutive cycles see the bookings of all earlier grants, so no two grants ever hold the same absolute unit cycle or the same absolute bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A booking request is present this cycle |
| req_start | input | IDX_W | Cycles until the last source operand is ready |
| req_dur | input | DUR_W | Cycles the unit needs before the result goes on the bus |
| grant | output | 1 | A slot was found and is being booked |
| stall | output | 1 | The request found no slot and must be retried |
| exec_dly | output | IDX_W | Granted delay until execution starts |
| wb_dly | output | IDX_W | Granted delay until write-back |

## Verification
Two things can fall in the same cycle: a new search, and the shift plus booking caused by the grant just before it. The bench provokes this by sending requests on consecutive cycles whose windows overlap slots booked one clock earlier. It also sends stalled requests whose window would have been free had the stall wrongly booked a slot. A behavioural model keeps its own occupancy arrays and books and shifts them after each clock edge. Every cycle, it predicts grant, stall and both delays, and these are compared with the outputs before the next edge.

// File: rtl/brt_pkg.sv
// Package: shared definitions for the slot finder.
// Assumes: nothing beyond IEEE 1800-2017.
package brt_pkg;

    // Result class of one search, used for readability in the top.
    typedef enum logic [1:0] {
        SRCH_IDLE  = 2'd0,
        SRCH_GRANT = 2'd1,
        SRCH_STALL = 2'd2
    } srch_res_e;

    // Largest of three widths, used to size candidate sums.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/brt_occ_table.sv
// Module: one future-occupancy vector.
// Bit i stands for the cycle i clocks ahead. Each clock the vector shifts
// toward index 0 with a 0 entering at the top; an optional booking is ORed
// in at set_idx before the shift.
// Assumes: set_idx < LEN whenever set_en is high.
module brt_occ_table #(
    parameter int LEN   = 32,
    parameter int IDX_W = $clog2(LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic [LEN-1:0]   tbl_o
);

    logic [LEN-1:0] tbl_q;
    logic [LEN-1:0] book_mask;

    // Decode the booking into a one-hot mask.
    always_comb begin
        book_mask = '0;
        if (set_en) book_mask[set_idx] = 1'b1;
    end

    // Book, then advance time by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= (tbl_q | book_mask) >> 1;
    end

    assign tbl_o = tbl_q;

    // A booked cycle one clock ahead must be the current cycle next clock.
    assert_shift_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_q[1] |=> tbl_q[0]);

    // A fresh booking at idx>0 shows up one position lower next clock.
    assert_book_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_idx != '0) |=> tbl_q[$past(set_idx) - 1'b1]);

endmodule

// File: rtl/brt_window.sv
// Module: builds the busy vector over the search window.
// For each offset j the candidate start is start+j and its bus cycle is
// start+j+dur; a candidate is busy when either index is out of the table
// or either resource is booked there.
// Assumes: WIN >= 2.
module brt_window
    import brt_pkg::*;
#(
    parameter int LEN   = 32,
    parameter int IDX_W = $clog2(LEN),
    parameter int WIN   = 4,
    parameter int DUR_W = 3
) (
    input  logic [IDX_W-1:0]          start_i,
    input  logic [DUR_W-1:0]          dur_i,
    input  logic [LEN-1:0]            fu_tbl_i,
    input  logic [LEN-1:0]            bus_tbl_i,
    output logic [WIN-1:0]            busy_o,
    output logic [WIN-1:0][IDX_W-1:0] ex_idx_o,
    output logic [WIN-1:0][IDX_W-1:0] wb_idx_o
);

    localparam int SUM_W = max3(IDX_W, DUR_W, $clog2(WIN)) + 2;

    for (genvar j = 0; j < WIN; j++) begin : g_cand
        logic [SUM_W-1:0] ex_sum;
        logic [SUM_W-1:0] wb_sum;
        logic             out_of_tbl;

        // Candidate start and write-back cycles for offset j.
        always_comb begin
            ex_sum = SUM_W'(start_i) + SUM_W'(j);
            wb_sum = ex_sum + SUM_W'(dur_i);
        end

        assign out_of_tbl  = (ex_sum >= SUM_W'(LEN)) || (wb_sum >= SUM_W'(LEN));
        assign ex_idx_o[j] = ex_sum[IDX_W-1:0];
        assign wb_idx_o[j] = wb_sum[IDX_W-1:0];

        // Unit busy at start, or bus busy at start plus duration.
        always_comb begin
            if (out_of_tbl) busy_o[j] = 1'b1;
            else            busy_o[j] = fu_tbl_i[ex_idx_o[j]] | bus_tbl_i[wb_idx_o[j]];
        end
    end

endmodule

// File: rtl/brt_prio_enc.sv
// Module: lowest-index free finder over the window.
// Assumes: WIN >= 2 so the offset is at least one bit wide.
module brt_prio_enc #(
    parameter int WIN   = 4,
    parameter int OFF_W = $clog2(WIN)
) (
    input  logic [WIN-1:0]   busy_i,
    output logic             found_o,
    output logic [OFF_W-1:0] off_o
);

    // Scan from the top so the lowest free offset wins.
    always_comb begin
        found_o = 1'b0;
        off_o   = '0;
        for (int i = WIN - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                found_o = 1'b1;
                off_o   = OFF_W'(i);
            end
        end
    end

endmodule

// File: rtl/brt_slot_finder.sv
// Module: top of the slot finder for one unit and its result bus.
// Search is combinational against the current (already shifted) vectors;
// grant books both resources at the next edge together with the shift.
// Assumes: a request is held only for the cycle it is presented.
module brt_slot_finder
    import brt_pkg::*;
#(
    parameter int LEN   = 32,
    parameter int WIN   = 4,
    parameter int DUR_W = 3,
    parameter int IDX_W = $clog2(LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_start,
    input  logic [DUR_W-1:0] req_dur,
    output logic             grant,
    output logic             stall,
    output logic [IDX_W-1:0] exec_dly,
    output logic [IDX_W-1:0] wb_dly
);

    localparam int OFF_W = $clog2(WIN);

    logic [LEN-1:0]            fu_tbl;
    logic [LEN-1:0]            bus_tbl;
    logic [WIN-1:0]            busy;
    logic [WIN-1:0][IDX_W-1:0] ex_idx;
    logic [WIN-1:0][IDX_W-1:0] wb_idx;
    logic                      found;
    logic [OFF_W-1:0]          off;
    srch_res_e                 res;

    brt_occ_table #(.LEN(LEN), .IDX_W(IDX_W)) u_fu_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (grant),
        .set_idx (exec_dly),
        .tbl_o   (fu_tbl)
    );

    brt_occ_table #(.LEN(LEN), .IDX_W(IDX_W)) u_bus_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (grant),
        .set_idx (wb_dly),
        .tbl_o   (bus_tbl)
    );

    brt_window #(.LEN(LEN), .IDX_W(IDX_W), .WIN(WIN), .DUR_W(DUR_W)) u_window (
        .start_i   (req_start),
        .dur_i     (req_dur),
        .fu_tbl_i  (fu_tbl),
        .bus_tbl_i (bus_tbl),
        .busy_o    (busy),
        .ex_idx_o  (ex_idx),
        .wb_idx_o  (wb_idx)
    );

    brt_prio_enc #(.WIN(WIN), .OFF_W(OFF_W)) u_prio (
        .busy_i  (busy),
        .found_o (found),
        .off_o   (off)
    );

    // Classify the search outcome for this cycle.
    always_comb begin
        if (!req_valid) res = SRCH_IDLE;
        else if (found) res = SRCH_GRANT;
        else            res = SRCH_STALL;
    end

    // Drive handshake and chosen delays from the outcome.
    always_comb begin
        grant    = (res == SRCH_GRANT);
        stall    = (res == SRCH_STALL);
        exec_dly = grant ? ex_idx[off] : '0;
        wb_dly   = grant ? wb_idx[off] : '0;
    end

    assert_exec_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (exec_dly >= req_start) &&
                  ((exec_dly - req_start) <= IDX_W'(WIN - 1)));

    assert_wb_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ({1'b0, wb_dly} == ({1'b0, exec_dly} + (IDX_W + 1)'(req_dur))));

    assert_grant_stall_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && stall));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grant && !stall));

    assert_no_double_book_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (!fu_tbl[exec_dly] && !bus_tbl[wb_dly]));

endmodule

// File: tb/brt_slot_finder_tb_top.sv
`timescale 1ns/1ps
module brt_slot_finder_tb_top;

    localparam int L   = 32;
    localparam int K   = 4;
    localparam int DW  = 3;
    localparam int IW  = $clog2(L);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_start = '0;
    logic [DW-1:0] req_dur = '0;
    logic          grant, stall;
    logic [IW-1:0] exec_dly, wb_dly;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int fu_m [L];
    int bus_m[L];

    always #2.5 clk = ~clk;

    brt_slot_finder #(.LEN(L), .WIN(K), .DUR_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_start(req_start), .req_dur(req_dur),
        .grant(grant), .stall(stall), .exec_dly(exec_dly), .wb_dly(wb_dly)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < L; i++) begin fu_m[i] = 0; bus_m[i] = 0; end
    endtask

    // One cycle: drive, predict, compare, then book and shift the model.
    task automatic step(input bit v, input int s, input int d, input string tag);
        int e_exp; bit ok;
        @(negedge clk);
        req_valid = v; req_start = IW'(s); req_dur = DW'(d);
        ok = 0; e_exp = 0;
        if (v) begin
            for (int j = K - 1; j >= 0; j--) begin
                int e = s + j;
                if (e < L && e + d < L && fu_m[e] == 0 && bus_m[e + d] == 0) begin
                    ok = 1; e_exp = e;
                end
            end
        end
        #1;
        chk(tag, "grant", int'(grant), int'(ok));
        chk(tag, "stall", int'(stall), int'(v && !ok));
        if (ok) begin
            chk(tag, "exec_dly", int'(exec_dly), e_exp);
            chk("R3", "wb_dly", int'(wb_dly), e_exp + d);
        end
        @(posedge clk);
        if (ok) begin fu_m[e_exp] = 1; bus_m[e_exp + d] = 1; end
        for (int i = 0; i < L - 1; i++) begin
            fu_m[i] = fu_m[i + 1]; bus_m[i] = bus_m[i + 1];
        end
        fu_m[L - 1] = 0; bus_m[L - 1] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(posedge clk);
        clear_model();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        clear_model();
        do_reset();
        // Reset state and idle behaviour.
        step(0, 0, 0, "R9");
        step(1, 2, 3, "R1");
        // Back-to-back overlap with a booking made one clock earlier.
        step(1, 3, 1, "R10");
        step(1, 2, 1, "R10");
        repeat (8) step(0, 0, 0, "R8");
        // Fill the window until it stalls.
        step(1, 10, 1, "R4");
        step(1, 9, 1, "R10");
        step(1, 8, 1, "R10");
        step(1, 7, 1, "R10");
        step(1, 6, 1, "R5");
        step(1, 5, 1, "R5");
        step(1, 8, 1, "R5");
        repeat (14) step(0, 0, 0, "R8");
        // Bus-only conflict pushes start by one.
        step(1, 4, 2, "R4");
        step(1, 4, 1, "R4");
        repeat (8) step(0, 0, 0, "R9");
        // Table end bounds.
        step(1, 31, 0, "R6");
        step(1, 31, 1, "R6");
        step(1, 30, 3, "R6");
        step(1, 27, 4, "R6");
        // Random traffic.
        for (int n = 0; n < 3000; n++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, L - 1),
                 $urandom_range(0, (1 << DW) - 1), "R7");
        // Reset out of a busy state.
        do_reset();
        step(1, 3, 2, "R1");
        step(0, 0, 0, "R9");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run did not finish got 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule